// File: doc/BRIEF.md
# Banked GPIO Controller with Interrupts

This block is a memory-mapped general-purpose I/O controller. By default it has 96 pins, arranged as three banks of 32 pins. Each pin has a direction bit, an output latch and an input polarity bit. The output latch can be loaded directly, or changed one bit at a time through separate set and clear registers. Because of these set and clear writes, software never needs a read-modify-write to change one pin.

Every pin input passes through a two-flop synchronizer. The synchronized value, inverted where the polarity bit is set, is called the sense value. Four independent arming masks watch the sense value: rising edge, falling edge, high level and low level. An armed condition sets a sticky pending bit, which software clears by writing a one to it. A second register records whether an edge caused the pending bit. The armed pending bits of all banks are ORed into one interrupt line.

Access goes through a simple 32-bit register bus. A write takes effect at the clock edge that accepts it. A read returns its data one cycle after the request.

Top module: `gpio_banked_ctrl`

## Requirements
- R1: After reset, all direction, polarity, output, arming, pending and edge registers are zero. `pin_oe`, `pin_out` and `irq` are low.
- R2: The register address is decoded as follows. `req_addr[7:4]` selects the function: 0 direction, 1 polarity, 2 data, 3 set, 4 clear, 5 rise-arm, 6 fall-arm, 7 high-arm, 8 low-arm, 9 pending, 10 edge-cause. `req_addr[3:2]` selects the bank. Bank index 3 and function codes 11 to 15 read as zero, and writes to them change nothing.
- R3: `pin_oe` bit i equals direction bit i. `pin_out` bit i equals output latch bit i. Writing the data register loads the latch.
- R4: A write to the set register forces to 1 every latch bit written as 1. Bits written as 0 keep their value.
- R5: A write to the clear register forces to 0 every latch bit written as 1. Bits written as 0 keep their value.
- R6: A read puts `rd_valid` high for exactly the next cycle, carrying the addressed register. A data read returns the latch bit for output pins. For input pins it returns the input after two synchronizer flops. The set and clear registers read as zero.
- R7: A polarity bit of 1 inverts the synchronized input before edge and level detection.
- R8: A rise-armed pin sets its pending bit and its edge-cause bit when its sense value goes from 0 to 1. A fall-armed pin does the same on a 1-to-0 change. A pin armed for both reacts to both edges.
- R9: A high-armed pin sets its pending bit in every cycle in which its sense value is 1, and a low-armed pin in every cycle in which it is 0. A level alone does not set the edge-cause bit.
- R10: Writing 1 to a pending bit clears that bit and its edge-cause bit. A clear wins over an event in the same cycle. A level that still holds sets the bit again one cycle later.
- R11: A pin with no arming bit set raises no new pending bit.
- R12: `irq` is high exactly when some pin, in any bank, has its pending bit set and at least one of its arming bits set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Bus request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 8 | Byte address of the register |
| req_wdata | input | 32 | Write data |
| rd_valid | output | 1 | Read data valid, one cycle after a read request |
| rd_data | output | 32 | Read data |
| pin_in | input | 96 | Pin input levels, asynchronous |
| pin_out | output | 96 | Output latch values |
| pin_oe | output | 96 | Output enables (direction) |
| irq | output | 1 | Combined interrupt |

## Verification
The bench uses the default parameters: three banks of 32 pins and an 8-bit address. With these values the unused bank index 3 and function codes 11 to 15 can be reached on the address bus, so the decode gaps of R2 get exercised. The interrupt line also collects status from a full 96-pin vector. Random register traffic is mixed with sparse random pin toggles. Together they reach simultaneous clear-and-event cycles, polarity flips while a pin is armed, and rise-and-fall arming on the same pin in every bank.

// File: rtl/gpio_ctrl_pkg.sv
package gpio_ctrl_pkg;

    localparam int FN_W       = 4;  // width of the function-select field
    localparam int FN_LSB     = 4;  // 16-byte function groups
    localparam int BANK_SEL_W = 2;  // bank index field width
    localparam int BANK_LSB   = 2;  // 4-byte bank stride

    typedef enum logic [FN_W-1:0] {
        FN_DIR  = 4'd0,
        FN_POL  = 4'd1,
        FN_DATA = 4'd2,
        FN_SET  = 4'd3,
        FN_CLR  = 4'd4,
        FN_RISE = 4'd5,
        FN_FALL = 4'd6,
        FN_HIGH = 4'd7,
        FN_LOW  = 4'd8,
        FN_STAT = 4'd9,
        FN_EDGE = 4'd10
    } gpio_fn_e;

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    typedef struct packed {
        logic [W-1:0] meta;
        logic [W-1:0] stable;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d.meta   = d;
        s_d.stable = s_q.meta;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign q = s_q.stable;
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
    import gpio_ctrl_pkg::*;
#(
    parameter int W = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [W-1:0]    sync_in,
    input  logic            wr_en,
    input  logic [FN_W-1:0] func,
    input  logic [W-1:0]    wdata,
    output logic [W-1:0]    rd_data,
    output logic [W-1:0]    pin_out,
    output logic [W-1:0]    pin_oe,
    output logic            irq_out
);
    typedef struct packed {
        logic [W-1:0] dir;
        logic [W-1:0] pol;
        logic [W-1:0] dat;
        logic [W-1:0] ren;
        logic [W-1:0] fen;
        logic [W-1:0] hen;
        logic [W-1:0] len;
        logic [W-1:0] st;
        logic [W-1:0] edg;
        logic [W-1:0] prv;
    } bank_t;

    bank_t        b_d, b_q;
    logic [W-1:0] sense, rise_ev, fall_ev, lvl_ev, clr_mask, armed;

    always_comb begin
        b_d      = b_q;
        sense    = sync_in ^ b_q.pol;
        rise_ev  = b_q.ren & sense & ~b_q.prv;
        fall_ev  = b_q.fen & ~sense & b_q.prv;
        lvl_ev   = (b_q.hen & sense) | (b_q.len & ~sense);
        clr_mask = '0;
        if (wr_en) begin
            case (func)
                FN_DIR:  b_d.dir = wdata;
                FN_POL:  b_d.pol = wdata;
                FN_DATA: b_d.dat = wdata;
                FN_SET:  b_d.dat = b_q.dat | wdata;
                FN_CLR:  b_d.dat = b_q.dat & ~wdata;
                FN_RISE: b_d.ren = wdata;
                FN_FALL: b_d.fen = wdata;
                FN_HIGH: b_d.hen = wdata;
                FN_LOW:  b_d.len = wdata;
                FN_STAT: clr_mask = wdata;
                default: ;
            endcase
        end
        b_d.prv = sense;
        b_d.st  = (b_q.st | rise_ev | fall_ev | lvl_ev) & ~clr_mask;
        b_d.edg = (b_q.edg | rise_ev | fall_ev) & ~clr_mask;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) b_q <= '0;
        else        b_q <= b_d;
    end

    always_comb begin
        case (func)
            FN_DIR:  rd_data = b_q.dir;
            FN_POL:  rd_data = b_q.pol;
            FN_DATA: rd_data = (b_q.dir & b_q.dat) | (~b_q.dir & sync_in);
            FN_RISE: rd_data = b_q.ren;
            FN_FALL: rd_data = b_q.fen;
            FN_HIGH: rd_data = b_q.hen;
            FN_LOW:  rd_data = b_q.len;
            FN_STAT: rd_data = b_q.st;
            FN_EDGE: rd_data = b_q.edg;
            default: rd_data = '0;
        endcase
    end

    assign armed   = b_q.ren | b_q.fen | b_q.hen | b_q.len;
    assign pin_out = b_q.dat;
    assign pin_oe  = b_q.dir;
    assign irq_out = |(b_q.st & armed);

    p_set_forces_ones_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && func == FN_SET) |=> ((pin_out & $past(wdata)) == $past(wdata)));

    p_clr_forces_zeros_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && func == FN_CLR) |=> ((pin_out & $past(wdata)) == '0));

    p_w1c_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && func == FN_STAT) |=> ((b_q.st & $past(wdata)) == '0));

    p_unarmed_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((b_q.st & ~$past(b_q.st) & ~$past(armed)) == '0));

    p_edge_needs_pending_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (b_q.edg & ~b_q.st) == '0);
endmodule

// File: rtl/gpio_banked_ctrl.sv
module gpio_banked_ctrl
    import gpio_ctrl_pkg::*;
#(
    parameter int NUM_BANKS = 3,
    parameter int BANK_W    = 32,
    parameter int ADDR_W    = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        req_valid,
    input  logic                        req_write,
    input  logic [ADDR_W-1:0]           req_addr,
    input  logic [BANK_W-1:0]           req_wdata,
    output logic                        rd_valid,
    output logic [BANK_W-1:0]           rd_data,
    input  logic [NUM_BANKS*BANK_W-1:0] pin_in,
    output logic [NUM_BANKS*BANK_W-1:0] pin_out,
    output logic [NUM_BANKS*BANK_W-1:0] pin_oe,
    output logic                        irq
);
    localparam int PINS = NUM_BANKS * BANK_W;

    typedef struct packed {
        logic              vld;
        logic [BANK_W-1:0] dat;
    } rsp_t;

    logic [PINS-1:0]       pin_sync;
    logic [FN_W-1:0]       fn_code;
    logic [BANK_SEL_W-1:0] bank_idx;
    logic [BANK_LSB-1:0]   addr_lsb_unused;
    logic [BANK_W-1:0]     bank_rd [NUM_BANKS];
    logic [NUM_BANKS-1:0]  bank_irq;
    rsp_t                  rsp_d, rsp_q;

    assign fn_code         = req_addr[FN_LSB +: FN_W];
    assign bank_idx        = req_addr[BANK_LSB +: BANK_SEL_W];
    assign addr_lsb_unused = req_addr[BANK_LSB-1:0];

    gpio_sync #(.W(PINS)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pin_in),
        .q     (pin_sync)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic hit_wr;
        assign hit_wr = req_valid && req_write && (bank_idx == BANK_SEL_W'(b));

        gpio_bank #(.W(BANK_W)) u_bank (
            .clk     (clk),
            .rst_n   (rst_n),
            .sync_in (pin_sync[b*BANK_W +: BANK_W]),
            .wr_en   (hit_wr),
            .func    (fn_code),
            .wdata   (req_wdata),
            .rd_data (bank_rd[b]),
            .pin_out (pin_out[b*BANK_W +: BANK_W]),
            .pin_oe  (pin_oe[b*BANK_W +: BANK_W]),
            .irq_out (bank_irq[b])
        );
    end

    always_comb begin
        rsp_d.vld = req_valid && !req_write;
        rsp_d.dat = '0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (bank_idx == BANK_SEL_W'(b)) rsp_d.dat = bank_rd[b];
        end
        if (!rsp_d.vld) rsp_d.dat = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rsp_q <= '0;
        else        rsp_q <= rsp_d;
    end

    assign rd_valid = rsp_q.vld;
    assign rd_data  = rsp_q.dat;
    assign irq      = |bank_irq;

    p_read_answers_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write) |=> rd_valid);

    p_no_stray_answer_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && !req_write) |=> !rd_valid);
endmodule

// File: tb/gpio_banked_ctrl_test.sv
`timescale 1ns/1ps
module gpio_banked_ctrl_test;
    localparam int NB = 3;
    localparam int W  = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0, req_write = 1'b0;
    logic [7:0]    req_addr = '0;
    logic [31:0]   req_wdata = '0;
    logic          rd_valid;
    logic [31:0]   rd_data;
    logic [95:0]   pin_in = '0;
    logic [95:0]   pin_out, pin_oe;
    logic          irq;

    int total = 0, bad = 0;
    bit done = 0;
    string cur_tag = "R6", exp_tag = "R6";

    always #2 clk = ~clk;

    gpio_banked_ctrl uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .rd_valid(rd_valid),
        .rd_data(rd_data), .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
        .irq(irq)
    );

    // reference model, built from the requirements
    logic [31:0] m_dir[NB], m_pol[NB], m_dat[NB], m_ren[NB], m_fen[NB];
    logic [31:0] m_hen[NB], m_len[NB], m_st[NB], m_edg[NB], m_prv[NB];
    logic [31:0] m_sy1[NB], m_sy2[NB];
    logic [31:0] exp_rd;
    bit          exp_valid;

    function automatic logic [31:0] mread(int f, int b);
        if (b >= NB) return '0;
        case (f)
            0: return m_dir[b];
            1: return m_pol[b];
            2: return (m_dir[b] & m_dat[b]) | (~m_dir[b] & m_sy2[b]);
            5: return m_ren[b];
            6: return m_fen[b];
            7: return m_hen[b];
            8: return m_len[b];
            9: return m_st[b];
            10: return m_edg[b];
            default: return '0;
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int b = 0; b < NB; b++) begin
                m_dir[b] = 0; m_pol[b] = 0; m_dat[b] = 0; m_ren[b] = 0; m_fen[b] = 0;
                m_hen[b] = 0; m_len[b] = 0; m_st[b] = 0; m_edg[b] = 0; m_prv[b] = 0;
                m_sy1[b] = 0; m_sy2[b] = 0;
            end
            exp_valid = 0;
        end else begin
            int f, bk;
            f  = int'(req_addr[7:4]);
            bk = int'(req_addr[3:2]);
            exp_valid = req_valid && !req_write;
            exp_rd    = exp_valid ? mread(f, bk) : '0;
            exp_tag   = cur_tag;
            for (int b = 0; b < NB; b++) begin
                logic [31:0] s, re, fe, le, clr;
                bit wr;
                wr  = req_valid && req_write && (bk == b);
                s   = m_sy2[b] ^ m_pol[b];
                re  = m_ren[b] & s & ~m_prv[b];
                fe  = m_fen[b] & ~s & m_prv[b];
                le  = (m_hen[b] & s) | (m_len[b] & ~s);
                clr = (wr && f == 9) ? req_wdata : '0;
                m_st[b]  = (m_st[b] | re | fe | le) & ~clr;
                m_edg[b] = (m_edg[b] | re | fe) & ~clr;
                m_prv[b] = s;
                m_sy2[b] = m_sy1[b];
                m_sy1[b] = pin_in[b*W +: W];
                if (wr) begin
                    case (f)
                        0: m_dir[b] = req_wdata;
                        1: m_pol[b] = req_wdata;
                        2: m_dat[b] = req_wdata;
                        3: m_dat[b] = m_dat[b] | req_wdata;
                        4: m_dat[b] = m_dat[b] & ~req_wdata;
                        5: m_ren[b] = req_wdata;
                        6: m_fen[b] = req_wdata;
                        7: m_hen[b] = req_wdata;
                        8: m_len[b] = req_wdata;
                        default: ;
                    endcase
                end
            end
        end
    end

    task automatic chk(string tag, logic [95:0] act, logic [95:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    // per-cycle comparison, sampled at the falling edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            logic ei;
            ei = 0;
            for (int b = 0; b < NB; b++)
                ei = ei | (|(m_st[b] & (m_ren[b] | m_fen[b] | m_hen[b] | m_len[b])));
            chk("R3 pin_oe", pin_oe, {m_dir[2], m_dir[1], m_dir[0]});
            chk("R3 pin_out", pin_out, {m_dat[2], m_dat[1], m_dat[0]});
            chk("R12 irq", 96'(irq), 96'(ei));
            chk("R6 rd_valid", 96'(rd_valid), 96'(exp_valid));
            if (exp_valid) chk(exp_tag, 96'(rd_data), 96'(exp_rd));
        end
    end

    task automatic op(bit wr, int f, int b, logic [31:0] d, string tag);
        @(negedge clk);
        req_valid = 1; req_write = wr;
        req_addr  = {f[3:0], b[1:0], 2'b00};
        req_wdata = d;
        cur_tag   = tag;
    endtask

    task automatic idle(int n);
        repeat (n) begin
            @(negedge clk);
            req_valid = 0;
        end
    endtask

    task automatic set_pins(logic [95:0] v);
        @(negedge clk);
        req_valid = 0;
        pin_in = v;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL R1 watchdog act=hung exp=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1: reset state at the pins and in every register
        chk("R1 pin_out", pin_out, '0);
        chk("R1 pin_oe", pin_oe, '0);
        chk("R1 irq", 96'(irq), '0);
        for (int f = 0; f <= 10; f++)
            for (int b = 0; b < NB; b++) op(0, f, b, '0, "R1 reset read");
        idle(2);

        // R3 direction and data latch
        op(1, 0, 1, 32'hFFFF0000, "R3");
        op(1, 2, 1, 32'h12345678, "R3");
        // R4 set, R5 clear
        op(1, 3, 1, 32'h0000000F, "R4");
        op(0, 2, 1, '0, "R4 data read");
        op(1, 4, 1, 32'h00000003, "R5");
        op(0, 2, 1, '0, "R5 data read");
        // R6 input read through the synchronizer
        set_pins(96'h0000000000000000000000A5);
        op(0, 2, 0, '0, "R6 early read");
        idle(3);
        op(0, 2, 0, '0, "R6 data read");
        // R2 decode gaps
        op(1, 0, 3, 32'hFFFFFFFF, "R2");
        op(1, 12, 0, 32'hFFFFFFFF, "R2");
        op(0, 0, 3, '0, "R2 bank3 read");
        op(0, 12, 0, '0, "R2 fn12 read");
        op(0, 0, 0, '0, "R2 bank0 dir unchanged");
        // R8 edges on bank 2: pin 64 rise-armed, pin 65 fall-armed, pin 66 both
        op(1, 5, 2, 32'h5, "R8");
        op(1, 6, 2, 32'h6, "R8");
        set_pins(pin_in | (96'h7 << 64));
        idle(3);
        op(0, 9, 2, '0, "R8 status after rise");
        op(0, 10, 2, '0, "R8 edge after rise");
        op(1, 9, 2, 32'hFFFFFFFF, "R8");
        set_pins(pin_in & ~(96'h7 << 64));
        idle(3);
        op(0, 9, 2, '0, "R8 status after fall");
        op(0, 10, 2, '0, "R8 edge after fall");
        // R9 high level on pin 7 (held high)
        op(1, 7, 0, 32'h80, "R9");
        idle(2);
        op(0, 9, 0, '0, "R9 level status");
        op(0, 10, 0, '0, "R9 no edge cause");
        // R10 clear then immediate re-set
        op(1, 9, 0, 32'h80, "R10");
        op(0, 9, 0, '0, "R10 cleared read");
        op(0, 9, 0, '0, "R10 re-set read");
        // R7 polarity turns low pin 4 into a high sense
        op(1, 7, 0, 32'h10, "R7");
        op(1, 9, 0, 32'hFFFFFFFF, "R7");
        op(1, 1, 0, 32'h10, "R7");
        idle(2);
        op(0, 9, 0, '0, "R7 inverted level");
        // R11 no arming: toggles raise nothing
        op(1, 7, 0, 32'h0, "R11");
        op(1, 1, 0, 32'h0, "R11");
        op(1, 9, 0, 32'hFFFFFFFF, "R11");
        set_pins(pin_in ^ 96'hFF);
        idle(3);
        set_pins(pin_in ^ 96'hFF);
        idle(3);
        op(0, 9, 0, '0, "R11 status");

        // random traffic
        for (int i = 0; i < 4000; i++) begin
            int k;
            k = $urandom_range(0, 9);
            if (k < 3) begin
                op(1, $urandom_range(0, 12), $urandom_range(0, 3),
                   $urandom & $urandom, "R6 random");
            end else if (k < 7) begin
                op(0, $urandom_range(0, 12), $urandom_range(0, 3), '0, "R6 random read");
            end else if (k < 9) begin
                set_pins(pin_in ^ ({$urandom, $urandom, $urandom} &
                         {$urandom, $urandom, $urandom} & {$urandom, $urandom, $urandom}));
            end else begin
                idle(1);
            end
        end
        idle(3);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule